// File: doc/BRIEF.md
# Drop Log Ring Buffer Controller

This block places fixed-size records about dropped packets into a circular region of memory. Software programs the region with a begin address and an exclusive end address. The end address is a look-ahead value: it is the address of the last word plus one word. The block keeps a hardware write pointer, which always names the next location it will write. Software owns a read pointer and advances it as it drains records.

When a record arrives and logging is enabled, the controller decides on the spot what to do with it. It writes the record if there is room. If there is no room it either overwrites unread data or discards the record. Each record is a burst of four 32-bit word writes on a simple request port, sent one word per cycle to consecutive addresses.

Software tells the block that it has consumed everything up to the end of the region by writing the end address into the read pointer. The pointer then reads back as the begin address. The memory itself, bus arbitration and the content of the records are outside the block.

Top module: `dlr_ring_ctrl`

## Requirements
- R1: After reset the begin address reads 0x0, the end address reads 0x1000, both pointers read 0x0, `busy` and `overflow` are low and no memory write is requested.
- R2: While `log_en` is low, a pulse on `rec_valid` causes no memory write and leaves the hardware pointer unchanged.
- R3: An accepted record is written as four word requests on four consecutive cycles, starting in the cycle after acceptance. The addresses are P, P+4, P+8 and P+12, where P is the hardware pointer at acceptance. The data are `rec_data[31:0]` first, then bits 63:32, 95:64 and 127:96. `busy` is high in exactly those four cycles.
- R4: At acceptance the hardware pointer advances by 16 bytes. If the result equals the end address, the pointer becomes the begin address and the region is marked as wrapped.
- R5: A `rec_valid` pulse that arrives while `busy` is high is ignored: no extra words are written and the pointer does not advance for it.
- R6: The region is full when it is wrapped and either the read pointer is below the hardware pointer or fewer than 16 bytes lie between the hardware pointer and the read pointer. When the region is full and `ovw_en` is low, the record is discarded with no memory write and `overflow` is set. `overflow` stays set until reset.
- R7: When the region is full and `ovw_en` is high, the record is written anyway at the hardware pointer, and `overflow` is not set by it.
- R8: A write to the read pointer of a value equal to the end address stores the begin address and clears the wrapped mark. A write of any other value stores that value.
- R9: The two low bits of any value written to the begin address, end address or either pointer are dropped, and the register reads back with those bits zero.
- R10: `reg_rdata` shows, without delay, the register chosen by `reg_sel`: 0 = begin address, 1 = end address, 2 = hardware pointer, 3 = read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| log_en | input | 1 | Enables acceptance of records |
| ovw_en | input | 1 | Allows overwriting unread data when full |
| rec_valid | input | 1 | One-cycle record strobe |
| rec_data | input | 128 | Four record words, word 0 in the low bits |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (see R10) |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Selected register value |
| mem_wr_req | output | 1 | Word write request |
| mem_wr_addr | output | 32 | Byte address of the word |
| mem_wr_data | output | 32 | Word to be written |
| busy | output | 1 | A record is being written |
| overflow | output | 1 | Sticky: a record was discarded |

## Verification
The bench drives the pointer across the end of a small region several times. This catches a design that wraps one record late or early, which shows up as writes past the end address. It fills the region until the hardware pointer meets an unacknowledged read pointer. It then checks that a design that tests only pointer equality, or ignores the wrapped mark, neither overwrites unread records when overwrite is off nor loses the record when overwrite is on. It also acknowledges a wrap through the end-address write, repeats a strobe during a burst, and writes misaligned addresses. These catch a design that keeps the end value literally in the read pointer, starts a second burst, or keeps the stray low bits.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
   typedef enum logic [1:0] {
      SEL_BEGIN = 2'd0,
      SEL_END   = 2'd1,
      SEL_HWPTR = 2'd2,
      SEL_SWPTR = 2'd3
   } reg_sel_e;

   localparam logic [31:0] END_RESET = 32'h0000_1000;
endpackage

// File: rtl/dlr_ptr_regs.sv
module dlr_ptr_regs #(
   parameter int AW        = 32,
   parameter int REC_BYTES = 16,
   parameter logic [AW-1:0] END_RST = AW'(32'h1000)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr_en,
   input  logic [1:0]    reg_sel,
   input  logic [AW-1:0] reg_wdata,
   input  logic          advance,
   output logic [AW-1:0] begin_q,
   output logic [AW-1:0] end_q,
   output logic [AW-1:0] hw_q,
   output logic [AW-1:0] sw_q,
   output logic          wrapped_q
);
   import dlr_pkg::*;

   logic [AW-1:0] wval;
   logic [AW-1:0] hw_step;
   logic [AW-1:0] hw_d, sw_d;
   logic          wrap_d;
   logic          sw_ack;

   assign wval    = {reg_wdata[AW-1:2], 2'b00};
   assign hw_step = hw_q + AW'(REC_BYTES);
   assign sw_ack  = reg_wr_en && (reg_sel == SEL_SWPTR) && (wval == end_q);

   always_comb begin
      hw_d   = hw_q;
      sw_d   = sw_q;
      wrap_d = wrapped_q;
      if (sw_ack) begin
         sw_d   = begin_q;
         wrap_d = 1'b0;
      end else if (reg_wr_en && reg_sel == SEL_SWPTR) begin
         sw_d = wval;
      end
      if (reg_wr_en && reg_sel == SEL_HWPTR) begin
         hw_d = wval;
      end else if (advance) begin
         if (hw_step == end_q) begin
            hw_d   = begin_q;
            wrap_d = 1'b1;
         end else begin
            hw_d = hw_step;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         begin_q   <= '0;
         end_q     <= END_RST;
         hw_q      <= '0;
         sw_q      <= '0;
         wrapped_q <= 1'b0;
      end else begin
         if (reg_wr_en && reg_sel == SEL_BEGIN) begin_q <= wval;
         if (reg_wr_en && reg_sel == SEL_END)   end_q   <= wval;
         hw_q      <= hw_d;
         sw_q      <= sw_d;
         wrapped_q <= wrap_d;
      end
   end
endmodule

// File: rtl/dlr_space_check.sv
module dlr_space_check #(
   parameter int AW        = 32,
   parameter int REC_BYTES = 16
) (
   input  logic [AW-1:0] hw_ptr,
   input  logic [AW-1:0] sw_ptr,
   input  logic          wrapped,
   output logic          room
);
   logic [AW-1:0] gap;

   assign gap  = sw_ptr - hw_ptr;
   assign room = !wrapped || ((sw_ptr >= hw_ptr) && (gap >= AW'(REC_BYTES)));
endmodule

// File: rtl/dlr_writer.sv
module dlr_writer #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int REC_WORDS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [AW-1:0]         base,
   input  logic [REC_WORDS*DW-1:0] rec_in,
   output logic                  busy,
   output logic                  mem_wr_req,
   output logic [AW-1:0]         mem_wr_addr,
   output logic [DW-1:0]         mem_wr_data
);
   localparam int CW         = $clog2(REC_WORDS);
   localparam int WORD_BYTES = DW / 8;

   logic [DW-1:0] words_in [REC_WORDS];
   logic [DW-1:0] words_q  [REC_WORDS];
   logic [CW-1:0] idx_q;
   logic [AW-1:0] base_q;
   logic          busy_q;

   for (genvar g = 0; g < REC_WORDS; g++) begin : g_unpack
      assign words_in[g] = rec_in[g*DW +: DW];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     words_q[g] <= '0;
         else if (start) words_q[g] <= words_in[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         base_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         base_q <= base;
      end else if (busy_q) begin
         if (idx_q == CW'(REC_WORDS - 1)) busy_q <= 1'b0;
         idx_q <= idx_q + 1'b1;
      end
   end

   assign busy        = busy_q;
   assign mem_wr_req  = busy_q;
   assign mem_wr_addr = base_q + AW'(idx_q) * AW'(WORD_BYTES);
   assign mem_wr_data = words_q[idx_q];
endmodule

// File: rtl/dlr_ring_ctrl.sv
module dlr_ring_ctrl #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int REC_WORDS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    log_en,
   input  logic                    ovw_en,
   input  logic                    rec_valid,
   input  logic [REC_WORDS*DW-1:0] rec_data,
   input  logic                    reg_wr_en,
   input  logic [1:0]              reg_sel,
   input  logic [AW-1:0]           reg_wdata,
   output logic [AW-1:0]           reg_rdata,
   output logic                    mem_wr_req,
   output logic [AW-1:0]           mem_wr_addr,
   output logic [DW-1:0]           mem_wr_data,
   output logic                    busy,
   output logic                    overflow
);
   import dlr_pkg::*;

   localparam int REC_BYTES = REC_WORDS * (DW / 8);

   if (REC_WORDS < 2 || (REC_WORDS & (REC_WORDS - 1)) != 0) begin : g_bad_words
      $error("REC_WORDS must be a power of two of at least 2");
   end
   if (DW % 32 != 0 || AW < 16) begin : g_bad_width
      $error("DW must be a multiple of 32 and AW at least 16");
   end

   logic [AW-1:0] begin_q, end_q, hw_q, sw_q;
   logic          wrapped_q;
   logic          room;
   logic          accept, do_write, do_drop;
   logic          ovf_q;

   assign accept   = rec_valid && log_en && !busy;
   assign do_write = accept && (room || ovw_en);
   assign do_drop  = accept && !room && !ovw_en;

   dlr_ptr_regs #(.AW(AW), .REC_BYTES(REC_BYTES), .END_RST(AW'(END_RESET))) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr_en (reg_wr_en),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .advance   (do_write),
      .begin_q   (begin_q),
      .end_q     (end_q),
      .hw_q      (hw_q),
      .sw_q      (sw_q),
      .wrapped_q (wrapped_q)
   );

   dlr_space_check #(.AW(AW), .REC_BYTES(REC_BYTES)) u_space (
      .hw_ptr  (hw_q),
      .sw_ptr  (sw_q),
      .wrapped (wrapped_q),
      .room    (room)
   );

   dlr_writer #(.AW(AW), .DW(DW), .REC_WORDS(REC_WORDS)) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (do_write),
      .base        (hw_q),
      .rec_in      (rec_data),
      .busy        (busy),
      .mem_wr_req  (mem_wr_req),
      .mem_wr_addr (mem_wr_addr),
      .mem_wr_data (mem_wr_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_q <= 1'b0;
      else if (do_drop) ovf_q <= 1'b1;
   end
   assign overflow = ovf_q;

   always_comb begin
      unique case (reg_sel_e'(reg_sel))
         SEL_BEGIN: reg_rdata = begin_q;
         SEL_END:   reg_rdata = end_q;
         SEL_HWPTR: reg_rdata = hw_q;
         default:   reg_rdata = sw_q;
      endcase
   end
endmodule

// File: rtl/dlr_ring_ctrl_chk.sv
module dlr_ring_ctrl_chk #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int REC_WORDS = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          log_en,
   input logic          busy,
   input logic          mem_wr_req,
   input logic [AW-1:0] mem_wr_addr,
   input logic          overflow,
   input logic [AW-1:0] reg_rdata
);
   localparam int RW = $clog2(REC_WORDS + 1) + 1;
   logic [RW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   assert_burst_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run_len == RW'(REC_WORDS));

   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && $past(mem_wr_req)) |-> mem_wr_addr == $past(mem_wr_addr) + AW'(DW / 8));

   assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!log_en && !busy) |=> !busy);

   assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(overflow) |-> overflow);

   assert_word_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[1:0] == 2'b00);

   assert_aligned_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> mem_wr_addr[1:0] == 2'b00);
endmodule

bind dlr_ring_ctrl dlr_ring_ctrl_chk #(.AW(AW), .DW(DW), .REC_WORDS(REC_WORDS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .log_en      (log_en),
   .busy        (busy),
   .mem_wr_req  (mem_wr_req),
   .mem_wr_addr (mem_wr_addr),
   .overflow    (overflow),
   .reg_rdata   (reg_rdata)
);

// File: tb/test_dlr_ring_ctrl.sv
module test_dlr_ring_ctrl;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         log_en = 1'b0, ovw_en = 1'b0, rec_valid = 1'b0;
   logic [127:0] rec_data = '0;
   logic         reg_wr_en = 1'b0;
   logic [1:0]   reg_sel = 2'd0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata, mem_wr_addr, mem_wr_data;
   logic         mem_wr_req, busy, overflow;

   int n_run = 0, n_fail = 0;
   logic [31:0] m_beg, m_end, m_hw, m_sw;
   logic        m_wrap, m_ovf;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dlr_ring_ctrl i_dlr_ring_ctrl (
      .clk(clk), .rst_n(rst_n), .log_en(log_en), .ovw_en(ovw_en),
      .rec_valid(rec_valid), .rec_data(rec_data),
      .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .busy(busy), .overflow(overflow)
   );

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not end, actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic model_room();
      return !m_wrap || ((m_sw >= m_hw) && (m_sw - m_hw >= 32'd16));
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_beg = 0; m_end = 32'h1000; m_hw = 0; m_sw = 0; m_wrap = 0; m_ovf = 0;
      @(negedge clk);
   endtask

   task automatic reg_wr(logic [1:0] sel, logic [31:0] val);
      reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = val;
      @(negedge clk);
      reg_wr_en = 1'b0;
      case (sel)
         2'd0: m_beg = {val[31:2], 2'b00};
         2'd1: m_end = {val[31:2], 2'b00};
         2'd2: m_hw  = {val[31:2], 2'b00};
         default: begin
            if ({val[31:2], 2'b00} == m_end) begin m_sw = m_beg; m_wrap = 0; end
            else m_sw = {val[31:2], 2'b00};
         end
      endcase
   endtask

   task automatic reg_chk(logic [1:0] sel, string tag);
      logic [31:0] e;
      reg_sel = sel;
      #1;
      case (sel)
         2'd0: e = m_beg;
         2'd1: e = m_end;
         2'd2: e = m_hw;
         default: e = m_sw;
      endcase
      check(tag, reg_rdata, e);
   endtask

   // Sends one record; optional second strobe during the burst (R5).
   task automatic send_rec(logic [127:0] d, logic restrobe);
      logic wr;
      logic [31:0] p;
      wr = log_en && (model_room() || ovw_en);
      p  = m_hw;
      if (log_en && !wr) m_ovf = 1;
      if (wr) begin
         m_hw = m_hw + 16;
         if (m_hw == m_end) begin m_hw = m_beg; m_wrap = 1; end
      end
      rec_data = d; rec_valid = 1'b1;
      @(negedge clk);
      rec_valid = 1'b0;
      if (wr) begin
         for (int i = 0; i < 4; i++) begin
            check("R3 req", {31'd0, mem_wr_req}, 32'd1);
            check("R3 busy", {31'd0, busy}, 32'd1);
            check("R3 addr", mem_wr_addr, p + 32'(4 * i));
            check("R3 data", mem_wr_data, d[32*i +: 32]);
            if (restrobe && i == 1) begin
               rec_data = ~d; rec_valid = 1'b1;
            end
            @(negedge clk);
            rec_valid = 1'b0;
         end
         check("R3 busy low after burst", {31'd0, busy}, 32'd0);
         check("R5 no second burst", {31'd0, mem_wr_req}, 32'd0);
      end else begin
         check(log_en ? "R6 dropped no req" : "R2 disabled no req",
               {31'd0, mem_wr_req}, 32'd0);
      end
      check("R6 overflow flag", {31'd0, overflow}, {31'd0, m_ovf});
      reg_chk(2'd2, "R4 hw pointer");
   endtask

   function automatic logic [127:0] rnd_rec();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      void'($urandom(32'd2718));
      do_reset();
      // R1 reset state
      reg_chk(2'd0, "R1 begin"); reg_chk(2'd1, "R1 end");
      reg_chk(2'd2, "R1 hw");    reg_chk(2'd3, "R1 sw");
      check("R1 busy", {31'd0, busy}, 0);
      check("R1 overflow", {31'd0, overflow}, 0);
      check("R1 req", {31'd0, mem_wr_req}, 0);
      // R9 / R10 alignment and readback
      reg_wr(2'd0, 32'h0000_0103); reg_chk(2'd0, "R9 begin low bits");
      reg_wr(2'd1, 32'h0000_0162); reg_chk(2'd1, "R9 end low bits");
      reg_wr(2'd1, 32'h0000_0160); reg_chk(2'd1, "R10 end select");
      reg_wr(2'd2, 32'h0000_0101); reg_chk(2'd2, "R9 hw low bits");
      reg_wr(2'd3, 32'h0000_0103); reg_chk(2'd3, "R9 sw low bits");
      // R2 disabled logging
      send_rec(rnd_rec(), 1'b0);
      log_en = 1'b1;
      // R3/R4 directed, R5 strobe during burst
      send_rec(128'h4444_4444_3333_3333_2222_2222_1111_1111, 1'b0);
      send_rec(rnd_rec(), 1'b1);
      // random traffic in a six-record region
      for (int it = 0; it < 300; it++) begin
         int op;
         op = int'($urandom % 10);
         if (op < 5) begin
            send_rec(rnd_rec(), op == 0);
         end else if (op < 9) begin
            logic [31:0] lim, nv;
            lim = m_wrap ? m_end : m_hw;
            nv  = m_sw + 32'(4 * ($urandom % 9));
            if (nv > lim) nv = lim;
            reg_wr(2'd3, nv);
            reg_chk(2'd3, "R8 sw pointer");
         end else begin
            log_en = 1'b0;
            send_rec(rnd_rec(), 1'b0);
            log_en = 1'b1;
         end
      end
      // directed full / ack / overwrite in a four-record region
      do_reset();
      log_en = 1'b1;
      reg_wr(2'd0, 32'h200); reg_wr(2'd1, 32'h240);
      reg_wr(2'd2, 32'h200); reg_wr(2'd3, 32'h200);
      for (int i = 0; i < 4; i++) send_rec(rnd_rec(), 1'b0);
      check("R4 wrapped to begin", m_hw, 32'h200);
      send_rec(rnd_rec(), 1'b0);
      check("R6 overflow set", {31'd0, overflow}, 32'd1);
      reg_wr(2'd3, 32'h240);
      reg_chk(2'd3, "R8 ack reads begin");
      send_rec(rnd_rec(), 1'b0);
      for (int i = 0; i < 3; i++) send_rec(rnd_rec(), 1'b0);
      ovw_en = 1'b1;
      send_rec(rnd_rec(), 1'b0);
      check("R7 overwrite advanced", m_hw, 32'h210);
      check("R6 overflow still set", {31'd0, overflow}, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule